// File: doc/BRIEF.md
# Multi-Channel Gamma Lookup Table

This block holds one flat 8-bit lookup memory shared by several display channels and applies it to a pixel stream. Each channel owns a contiguous region of 768 entries: the red sub-table comes first, the green one follows it, and the blue one comes last. Each sub-table has 256 entries. A host loads the memory through a pointer port and a data port. An auto-increment flag, latched with the pointer, makes a run of data writes fill consecutive entries without a pointer write between them.

In the pixel path, each beat carries a channel index, three 8-bit components and valid, horizontal-sync and vertical-sync flags. When gamma is enabled for the beat's channel, each component is replaced by the entry it indexes in that channel's matching sub-table. Otherwise the components pass through unchanged. Both paths take exactly one register stage, and the flags are delayed by the same stage. At reset every sub-table holds an identity ramp. Table writes are accepted whatever the enables are, so the contents can be rewritten after gamma was switched off on every channel.

Top module: `gamma_lut`

## Requirements
- R1: After reset every sub-table entry at offset i (0..255) holds the value i, the pointer is 0, auto-increment is off, and all outputs are 0.
- R2: Channel c's region starts at address c*768. Red component v reads address c*768+v, green reads c*768+256+v and blue reads c*768+512+v. A write to one channel's region leaves the lookups of other channels unchanged.
- R3: A pointer write (tbl_addr_we) loads tbl_addr, or 0 when tbl_addr is at least NUM_CH*768, and latches tbl_autoinc. A data write (tbl_data_we) stores tbl_data at the current pointer. When both strobes arrive in one cycle, the data goes to the old pointer and the pointer then takes the new value.
- R4: With auto-increment latched as 1, each data write advances the pointer by one.
- R5: With auto-increment latched as 0, data writes leave the pointer unchanged, so repeated writes overwrite the same entry.
- R6: An auto-increment step from the last address (NUM_CH*768-1) wraps the pointer to 0.
- R7: When gamma_en[in_chan] is 1, out_r, out_g and out_b equal the looked-up entries one clock after the input beat.
- R8: When gamma_en[in_chan] is 0, out_r, out_g and out_b equal in_r, in_g and in_b one clock later.
- R9: out_valid, out_hsync and out_vsync equal in_valid, in_hsync and in_vsync delayed by one clock.
- R10: Table writes take effect while every gamma enable is 0, and the new contents are used once gamma is enabled again.
- R11: A lookup made in the same cycle as a write to the same entry returns the entry's previous contents.
- R12: A channel index of NUM_CH or more always bypasses the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_addr_we | input | 1 | Load the table pointer and the auto-increment flag |
| tbl_addr | input | AW | New pointer value (AW = clog2(NUM_CH*768)) |
| tbl_autoinc | input | 1 | Auto-increment flag, latched together with the pointer |
| tbl_data_we | input | 1 | Write tbl_data at the pointer |
| tbl_data | input | 8 | Table entry value |
| gamma_en | input | NUM_CH | Per-channel gamma enable |
| in_valid | input | 1 | Input beat valid |
| in_hsync | input | 1 | Input horizontal sync |
| in_vsync | input | 1 | Input vertical sync |
| in_chan | input | CHW | Channel index of the input beat |
| in_r | input | 8 | Red component |
| in_g | input | 8 | Green component |
| in_b | input | 8 | Blue component |
| out_valid | output | 1 | Delayed valid |
| out_hsync | output | 1 | Delayed horizontal sync |
| out_vsync | output | 1 | Delayed vertical sync |
| out_r | output | 8 | Corrected red |
| out_g | output | 8 | Corrected green |
| out_b | output | 8 | Corrected blue |

## Verification
A corrupted pointer or auto-increment flag stays hidden at the write side. It shows up only when a later lookup of an entry that should have been written returns a stale or misplaced value, one clock after that beat is presented. A wrong region base or sub-table offset shows on the first enabled beat whose channel or colour differs from the one that was loaded. A lost or extra delay on the flags or on the bypass path shows on the first clock after any change of the inputs. The reference model tracks pointer, flag and memory separately from the design and compares every output on every clock, so each of these errors is reported within one beat of the lookup that exposes it.

// File: rtl/gamma_pkg.sv
package gamma_pkg;

    localparam int COMP_W  = 8;
    localparam int ENTRIES = 256;
    localparam int COMPS   = 3;
    localparam int REGION  = COMPS * ENTRIES;

    typedef logic [COMP_W-1:0] comp_t;

    typedef struct packed {
        comp_t r;
        comp_t g;
        comp_t b;
    } rgb_t;

    typedef struct packed {
        logic valid;
        logic hsync;
        logic vsync;
    } ctl_t;

    function automatic int chan_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/gamma_addr_ctrl.sv
module gamma_addr_ctrl #(
    parameter int DEPTH = 2304,
    parameter int AW    = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          addr_we,
    input  logic [AW-1:0] addr_in,
    input  logic          autoinc_in,
    input  logic          data_we,
    output logic [AW-1:0] ptr
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic inc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr   <= '0;
            inc_q <= 1'b0;
        end else if (addr_we) begin
            ptr   <= (32'(addr_in) >= DEPTH) ? '0 : addr_in;
            inc_q <= autoinc_in;
        end else if (data_we && inc_q) begin
            ptr <= (ptr == LAST) ? '0 : ptr + AW'(1);
        end
    end

    assert_autoinc_step_R4: assert property (@(posedge clk) disable iff (rst)
        (data_we && !addr_we && inc_q && ptr != LAST) |=> ptr == $past(ptr) + AW'(1));

    assert_hold_no_inc_R5: assert property (@(posedge clk) disable iff (rst)
        (!addr_we && !(data_we && inc_q)) |=> $stable(ptr));

    assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (data_we && !addr_we && inc_q && ptr == LAST) |=> ptr == '0);

    assert_ptr_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        32'(ptr) < DEPTH);

endmodule

// File: rtl/gamma_table.sv
module gamma_table
    import gamma_pkg::*;
#(
    parameter int DEPTH = 2304,
    parameter int AW    = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  comp_t                    wdata,
    input  logic [COMPS-1:0][AW-1:0] raddr,
    output comp_t [COMPS-1:0]        rdata
);

    comp_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= COMP_W'(i % ENTRIES);
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < COMPS; p++) begin : g_rd
        always_ff @(posedge clk) begin
            if (rst) rdata[p] <= '0;
            else     rdata[p] <= mem[raddr[p]];
        end
    end

endmodule

// File: rtl/gamma_lookup.sv
module gamma_lookup
    import gamma_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CHW    = 2,
    parameter int AW     = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CH-1:0]        gamma_en,
    input  ctl_t                     in_ctl,
    input  logic [CHW-1:0]           in_chan,
    input  rgb_t                     in_pix,
    output logic [COMPS-1:0][AW-1:0] raddr,
    input  comp_t [COMPS-1:0]        rdata,
    output ctl_t                     out_ctl,
    output rgb_t                     out_pix
);

    logic          chan_ok;
    logic          use_d;
    logic [AW-1:0] base;
    comp_t [COMPS-1:0] comp_in;

    ctl_t ctl_q;
    rgb_t raw_q;
    logic use_q;

    assign chan_ok    = 32'(in_chan) < NUM_CH;
    assign use_d      = chan_ok && gamma_en[in_chan];
    assign comp_in[0] = in_pix.r;
    assign comp_in[1] = in_pix.g;
    assign comp_in[2] = in_pix.b;

    always_comb begin
        base = chan_ok ? AW'(32'(in_chan) * REGION) : '0;
        for (int c = 0; c < COMPS; c++) begin
            raddr[c] = base + AW'(c * ENTRIES) + AW'(comp_in[c]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            raw_q <= '0;
            use_q <= 1'b0;
        end else begin
            ctl_q <= in_ctl;
            raw_q <= in_pix;
            use_q <= use_d;
        end
    end

    assign out_ctl   = ctl_q;
    assign out_pix.r = use_q ? rdata[0] : raw_q.r;
    assign out_pix.g = use_q ? rdata[1] : raw_q.g;
    assign out_pix.b = use_q ? rdata[2] : raw_q.b;

    assert_ctl_delay_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> out_ctl == $past(in_ctl));

    assert_bypass_R8: assert property (@(posedge clk) disable iff (rst)
        (chan_ok && !gamma_en[in_chan]) |=> out_pix == $past(in_pix));

    assert_bad_chan_bypass_R12: assert property (@(posedge clk) disable iff (rst)
        !chan_ok |=> out_pix == $past(in_pix));

endmodule

// File: rtl/gamma_lut.sv
module gamma_lut
    import gamma_pkg::*;
#(
    parameter int NUM_CH = 3,
    localparam int DEPTH = NUM_CH * REGION,
    localparam int AW    = $clog2(DEPTH),
    localparam int CHW   = chan_width(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tbl_addr_we,
    input  logic [AW-1:0]     tbl_addr,
    input  logic              tbl_autoinc,
    input  logic              tbl_data_we,
    input  logic [7:0]        tbl_data,
    input  logic [NUM_CH-1:0] gamma_en,
    input  logic              in_valid,
    input  logic              in_hsync,
    input  logic              in_vsync,
    input  logic [CHW-1:0]    in_chan,
    input  logic [7:0]        in_r,
    input  logic [7:0]        in_g,
    input  logic [7:0]        in_b,
    output logic              out_valid,
    output logic              out_hsync,
    output logic              out_vsync,
    output logic [7:0]        out_r,
    output logic [7:0]        out_g,
    output logic [7:0]        out_b
);

    logic [AW-1:0]            ptr;
    logic [COMPS-1:0][AW-1:0] raddr;
    comp_t [COMPS-1:0]        rdata;
    ctl_t                     in_ctl, out_ctl;
    rgb_t                     in_pix, out_pix;

    assign in_ctl = '{valid: in_valid, hsync: in_hsync, vsync: in_vsync};
    assign in_pix = '{r: in_r, g: in_g, b: in_b};

    gamma_addr_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .addr_we    (tbl_addr_we),
        .addr_in    (tbl_addr),
        .autoinc_in (tbl_autoinc),
        .data_we    (tbl_data_we),
        .ptr        (ptr)
    );

    gamma_table #(.DEPTH(DEPTH), .AW(AW)) u_table (
        .clk   (clk),
        .rst   (rst),
        .we    (tbl_data_we),
        .waddr (ptr),
        .wdata (tbl_data),
        .raddr (raddr),
        .rdata (rdata)
    );

    gamma_lookup #(.NUM_CH(NUM_CH), .CHW(CHW), .AW(AW)) u_lookup (
        .clk      (clk),
        .rst      (rst),
        .gamma_en (gamma_en),
        .in_ctl   (in_ctl),
        .in_chan  (in_chan),
        .in_pix   (in_pix),
        .raddr    (raddr),
        .rdata    (rdata),
        .out_ctl  (out_ctl),
        .out_pix  (out_pix)
    );

    assign out_valid = out_ctl.valid;
    assign out_hsync = out_ctl.hsync;
    assign out_vsync = out_ctl.vsync;
    assign out_r     = out_pix.r;
    assign out_g     = out_pix.g;
    assign out_b     = out_pix.b;

    assert_reset_out_R1: assert property (@(posedge clk)
        rst |=> (out_valid == 1'b0 && out_r == 8'd0 && out_g == 8'd0 && out_b == 8'd0));

endmodule

// File: tb/gamma_lut_tb.sv
module gamma_lut_tb;

    localparam int CLK_P  = 10;
    localparam int NUM_CH = 3;
    localparam int DEPTH  = NUM_CH * 768;
    localparam int AW     = $clog2(DEPTH);
    localparam int CHW    = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tbl_addr_we = 1'b0;
    logic [AW-1:0]     tbl_addr = '0;
    logic              tbl_autoinc = 1'b0;
    logic              tbl_data_we = 1'b0;
    logic [7:0]        tbl_data = '0;
    logic [NUM_CH-1:0] gamma_en = '0;
    logic              in_valid = 1'b0, in_hsync = 1'b0, in_vsync = 1'b0;
    logic [CHW-1:0]    in_chan = '0;
    logic [7:0]        in_r = '0, in_g = '0, in_b = '0;
    logic              out_valid, out_hsync, out_vsync;
    logic [7:0]        out_r, out_g, out_b;

    always #(CLK_P/2) clk = ~clk;

    gamma_lut #(.NUM_CH(NUM_CH)) u_dut (
        .clk(clk), .rst(rst),
        .tbl_addr_we(tbl_addr_we), .tbl_addr(tbl_addr), .tbl_autoinc(tbl_autoinc),
        .tbl_data_we(tbl_data_we), .tbl_data(tbl_data), .gamma_en(gamma_en),
        .in_valid(in_valid), .in_hsync(in_hsync), .in_vsync(in_vsync),
        .in_chan(in_chan), .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .out_valid(out_valid), .out_hsync(out_hsync), .out_vsync(out_vsync),
        .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    // Reference model
    int  mm [DEPTH];
    int  m_ptr;
    bit  m_inc;
    int  e_r, e_g, e_b;
    bit  e_v, e_h, e_s;
    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    string cur_req = "R1";

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mm[i] = i % 256;
            m_ptr = 0; m_inc = 0;
            e_r = 0; e_g = 0; e_b = 0; e_v = 0; e_h = 0; e_s = 0;
        end else begin
            int ch;
            ch = int'(in_chan);
            e_v = in_valid; e_h = in_hsync; e_s = in_vsync;
            if (ch < NUM_CH && gamma_en[ch]) begin
                e_r = mm[ch*768 + int'(in_r)];
                e_g = mm[ch*768 + 256 + int'(in_g)];
                e_b = mm[ch*768 + 512 + int'(in_b)];
            end else begin
                e_r = int'(in_r); e_g = int'(in_g); e_b = int'(in_b);
            end
            if (tbl_data_we) mm[m_ptr] = int'(tbl_data);
            if (tbl_addr_we) begin
                m_ptr = (int'(tbl_addr) >= DEPTH) ? 0 : int'(tbl_addr);
                m_inc = tbl_autoinc;
            end else if (tbl_data_we && m_inc) begin
                m_ptr = (m_ptr + 1) % DEPTH;
            end
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("out_valid", int'(out_valid), int'(e_v));
            chk("out_hsync", int'(out_hsync), int'(e_h));
            chk("out_vsync", int'(out_vsync), int'(e_s));
            chk("out_r", int'(out_r), e_r);
            chk("out_g", int'(out_g), e_g);
            chk("out_b", int'(out_b), e_b);
        end
    end

    task automatic idle();
        tbl_addr_we = 0; tbl_data_we = 0; in_valid = 0;
    endtask

    task automatic pix(input int ch, input int r, input int g, input int b);
        @(negedge clk);
        idle();
        in_valid = 1; in_hsync = ~in_hsync; in_vsync = (r == 0);
        in_chan = CHW'(ch); in_r = 8'(r); in_g = 8'(g); in_b = 8'(b);
    endtask

    task automatic set_ptr(input int a, input bit inc);
        @(negedge clk);
        idle();
        tbl_addr_we = 1; tbl_addr = AW'(a); tbl_autoinc = inc;
    endtask

    task automatic wr(input int d);
        @(negedge clk);
        idle();
        tbl_data_we = 1; tbl_data = 8'(d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset values at the ports
        cur_req = "R1";
        chk("reset out_r", int'(out_r), 0);
        chk("reset out_valid", int'(out_valid), 0);
        gamma_en = '1;
        for (int c = 0; c < NUM_CH; c++)
            for (int v = 0; v < 256; v += 37) pix(c, v, 255 - v, v ^ 8'h33);

        // R4 R7 R2: fill channel 1 with auto-increment
        cur_req = "R4";
        set_ptr(768, 1);
        for (int i = 0; i < 768; i++) wr((i < 256) ? 255 - i : (i < 512) ? (i ^ 8'h5a) & 255 : (i + 1) & 255);
        cur_req = "R7";
        for (int v = 0; v < 256; v += 5) pix(1, v, v, v);
        cur_req = "R2";
        for (int v = 0; v < 256; v += 23) pix(0, v, v, v);
        for (int v = 0; v < 256; v += 23) pix(2, v, v, v);

        // R8: channel 1 disabled
        cur_req = "R8";
        gamma_en = 3'b101;
        for (int v = 0; v < 256; v += 17) pix(1, v, 255 - v, v);

        // R5: no auto-increment, overwrite one entry
        cur_req = "R5";
        gamma_en = '1;
        set_ptr(2*768 + 256 + 44, 0);
        wr(7); wr(9); wr(200);
        pix(2, 44, 44, 44);
        pix(2, 45, 45, 45);

        // R6: wrap from last address
        cur_req = "R6";
        set_ptr(DEPTH - 1, 1);
        wr(11); wr(22); wr(33);
        pix(2, 0, 0, 255);
        pix(0, 0, 0, 0);
        pix(0, 1, 1, 1);

        // R3: out-of-range pointer and simultaneous strobes
        cur_req = "R3";
        set_ptr(4000, 1);
        wr(99);
        pix(0, 0, 0, 0);
        @(negedge clk); idle();
        tbl_data_we = 1; tbl_data = 8'd77; tbl_addr_we = 1; tbl_addr = AW'(768 + 512 + 3); tbl_autoinc = 1;
        wr(66);
        pix(0, 1, 1, 1);
        pix(1, 0, 0, 3);
        pix(1, 0, 0, 2);

        // R10: write with all enables off, then re-enable
        cur_req = "R10";
        gamma_en = '0;
        set_ptr(0, 1);
        for (int i = 0; i < 8; i++) wr(100 + i);
        pix(0, 3, 3, 3);
        gamma_en = '1;
        for (int v = 0; v < 10; v++) pix(0, v, v, v);

        // R11: lookup in the same cycle as a write to that entry
        cur_req = "R11";
        set_ptr(5, 0);
        @(negedge clk); idle();
        tbl_data_we = 1; tbl_data = 8'd250;
        in_valid = 1; in_chan = 0; in_r = 8'd5; in_g = 8'd0; in_b = 8'd0;
        pix(0, 5, 5, 5);

        // R12: out-of-range channel index
        cur_req = "R12";
        for (int v = 0; v < 256; v += 51) pix(3, v, v + 1, v + 2);

        // R9: random mixture
        cur_req = "R9";
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            idle();
            gamma_en = NUM_CH'($urandom);
            in_valid = 1'($urandom); in_hsync = 1'($urandom); in_vsync = 1'($urandom);
            in_chan = CHW'($urandom);
            in_r = 8'($urandom); in_g = 8'($urandom); in_b = 8'($urandom);
            if (($urandom % 4) == 0) begin
                tbl_data_we = 1; tbl_data = 8'($urandom);
            end
        end
        @(negedge clk); idle();
        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule